// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block builds the second operand of a data processing ALU, together with the carry the shifter hands to the flag logic. It is purely combinational, and one instance sits between the register read ports and the ALU input.

There are two operand forms. In immediate mode, an 8-bit constant is zero-extended to 32 bits and rotated right by twice a 4-bit rotate field, which reaches many useful 32-bit constants. In register mode, a register value is shifted by one of four shift kinds. The shift count comes either from a 5-bit instruction field or from the low byte of a second register. The second source allows counts of 32 and above, which need their own handling. A left shift by a constant also gives the ALU a cheap multiply by a power of two.

Top module: `op2_barrel_shifter`

## Requirements
- R1: With `use_imm`=1 and `imm_rot`≠0, `op2_out` is the zero-extended `imm_val` rotated right by 2×`imm_rot` places, and `shc_out` equals `op2_out[31]`.
- R2: With `use_imm`=1 and `imm_rot`=0, `op2_out` is the zero-extended `imm_val` and `shc_out` equals `flag_c`.
- R3: In register mode with a count n from 1 to 31, `sh_kind` selects the shift. 00 is a left logical shift with carry `reg_val[32-n]`. 01 is a right logical shift with carry `reg_val[n-1]`. 10 is a right arithmetic shift with carry `reg_val[n-1]`. 11 is a right rotate with carry `reg_val[n-1]`.
- R4: In register mode, a count of zero from either source gives `op2_out`=`reg_val` and `shc_out`=`flag_c`.
- R5: `amt_sel_reg`=1 takes the count from `amt_reg`, and 0 takes it from `amt_imm`. The unselected count input has no effect.
- R6: With a register count of exactly 32, kinds 00 and 01 give 0. The carry is `reg_val[0]` for kind 00 and `reg_val[31]` for kind 01.
- R7: With a register count above 32, kinds 00 and 01 give 0 with carry 0.
- R8: Kind 10 with a register count of 32 or more gives 32 copies of `reg_val[31]`, with carry `reg_val[31]`.
- R9: Kind 11 with a register count of 32 or more rotates by the count modulo 32. A nonzero multiple of 32 gives `reg_val` unchanged, with carry `reg_val[31]`.
- R10: In immediate mode, `reg_val`, `sh_kind`, `amt_sel_reg`, `amt_imm` and `amt_reg` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | 1 selects the rotated-immediate form |
| imm_val | input | 8 | Immediate constant |
| imm_rot | input | 4 | Rotate field; the rotation is twice this value |
| reg_val | input | 32 | Register operand to be shifted |
| sh_kind | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| amt_sel_reg | input | 1 | 1 takes the count from `amt_reg` |
| amt_imm | input | 5 | Count from the instruction field |
| amt_reg | input | 8 | Count from the low byte of a register |
| flag_c | input | 1 | Current carry flag |
| op2_out | output | 32 | Second operand for the ALU |
| shc_out | output | 1 | Shifter carry-out |

## Verification
The assertions assume that every input is a defined 0 or 1 whenever the outputs are examined. They also assume that the inputs of the mode that is not selected may hold any value at all. Because of this, no property in immediate mode may depend on the register-side fields, and no property in register mode may depend on the immediate fields. The stimulus drives every input on every vector, including the unused ones, from a seeded random source. It concentrates register counts on 0, 1, 31, 32, 33 and multiples of 32, so that the count boundaries are visited far more often than uniform draws would visit them.

// File: rtl/op2_shift_pkg.sv
package op2_shift_pkg;
   typedef enum logic [1:0] {
      SK_LSL = 2'b00,
      SK_LSR = 2'b01,
      SK_ASR = 2'b10,
      SK_ROR = 2'b11
   } shift_kind_e;
endpackage

// File: rtl/op2_amount_decode.sv
module op2_amount_decode #(
   parameter int DATA_W    = 32,
   parameter int FIELD_W   = 5,
   parameter int REG_AMT_W = 8,
   localparam int SH_W     = $clog2(DATA_W),
   localparam int RAW_W    = (FIELD_W > REG_AMT_W) ? FIELD_W : REG_AMT_W
) (
   input  logic                       sel_reg,
   input  logic [FIELD_W-1:0]         field_amt,
   input  logic [REG_AMT_W-1:0]       reg_amt,
   input  op2_shift_pkg::shift_kind_e kind,
   output logic                       amt_zero,
   output logic                       force_zero,
   output logic                       keep_rot,
   output logic [SH_W:0]              eff_amt
);
   import op2_shift_pkg::*;

   localparam logic [RAW_W-1:0] FULL = RAW_W'(DATA_W);

   logic [RAW_W-1:0] raw;
   logic             over;

   assign raw      = sel_reg ? RAW_W'(reg_amt) : RAW_W'(field_amt);
   assign amt_zero = (raw == '0);
   assign over     = (raw > FULL);

   always_comb begin
      force_zero = 1'b0;
      keep_rot   = 1'b0;
      eff_amt    = raw[SH_W:0];
      unique case (kind)
         SK_LSL, SK_LSR: begin
            force_zero = over;
            if (over) eff_amt = FULL[SH_W:0];
         end
         SK_ASR: begin
            if (over) eff_amt = FULL[SH_W:0];
         end
         SK_ROR: begin
            eff_amt  = {1'b0, raw[SH_W-1:0]};
            keep_rot = !amt_zero && (raw[SH_W-1:0] == '0);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/op2_shift_core.sv
module op2_shift_core #(
   parameter int DATA_W = 32,
   localparam int SH_W  = $clog2(DATA_W),
   localparam int EXT_W = 2 * DATA_W + 1
) (
   input  logic [DATA_W-1:0]          val,
   input  op2_shift_pkg::shift_kind_e kind,
   input  logic [SH_W:0]              amt,
   output logic [DATA_W-1:0]          res,
   output logic                       cout
);
   import op2_shift_pkg::*;

   logic [DATA_W-1:0] val_rev, src, fill, mid, mid_rev;
   logic [EXT_W-1:0]  stg [0:SH_W+1];
   logic              left;

   assign left = (kind == SK_LSL);

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign val_rev[i] = val[DATA_W-1-i];
      assign mid_rev[i] = mid[DATA_W-1-i];
   end

   assign src = left ? val_rev : val;

   always_comb begin
      unique case (kind)
         SK_ASR:  fill = {DATA_W{val[DATA_W-1]}};
         SK_ROR:  fill = val;
         default: fill = '0;
      endcase
   end

   assign stg[0] = {fill, src, 1'b0};

   for (genvar k = 0; k <= SH_W; k++) begin : g_stage
      assign stg[k+1] = amt[k] ? (stg[k] >> (2 ** k)) : stg[k];
   end

   assign mid  = stg[SH_W+1][DATA_W:1];
   assign cout = stg[SH_W+1][0];
   assign res  = left ? mid_rev : mid;
endmodule

// File: rtl/op2_barrel_shifter.sv
module op2_barrel_shifter #(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 8,
   parameter int ROT_W     = 4,
   parameter int FIELD_W   = 5,
   parameter int REG_AMT_W = 8,
   localparam int SH_W     = $clog2(DATA_W)
) (
   input  logic                 use_imm,
   input  logic [IMM_W-1:0]     imm_val,
   input  logic [ROT_W-1:0]     imm_rot,
   input  logic [DATA_W-1:0]    reg_val,
   input  logic [1:0]           sh_kind,
   input  logic                 amt_sel_reg,
   input  logic [FIELD_W-1:0]   amt_imm,
   input  logic [REG_AMT_W-1:0] amt_reg,
   input  logic                 flag_c,
   output logic [DATA_W-1:0]    op2_out,
   output logic                 shc_out
);
   import op2_shift_pkg::*;

   if (DATA_W != (2 ** SH_W))     begin : g_err_w   $error("DATA_W must be a power of two");  end
   if (IMM_W > DATA_W)            begin : g_err_imm $error("IMM_W exceeds DATA_W");           end
   if (ROT_W + 1 > SH_W)          begin : g_err_rot $error("rotation range exceeds DATA_W");  end
   if (FIELD_W > SH_W)            begin : g_err_fld $error("field count reaches DATA_W");     end
   if (REG_AMT_W <= SH_W)         begin : g_err_reg $error("register count cannot reach DATA_W"); end

   shift_kind_e       kind_reg, core_kind;
   logic [DATA_W-1:0] core_val, core_res;
   logic [SH_W:0]     dec_amt, imm_amt, core_amt;
   logic              core_c, amt_zero, force_zero, keep_rot, bypass;

   assign kind_reg = shift_kind_e'(sh_kind);

   op2_amount_decode #(
      .DATA_W(DATA_W), .FIELD_W(FIELD_W), .REG_AMT_W(REG_AMT_W)
   ) i_dec (
      .sel_reg    (amt_sel_reg),
      .field_amt  (amt_imm),
      .reg_amt    (amt_reg),
      .kind       (kind_reg),
      .amt_zero   (amt_zero),
      .force_zero (force_zero),
      .keep_rot   (keep_rot),
      .eff_amt    (dec_amt)
   );

   assign imm_amt   = (SH_W + 1)'({imm_rot, 1'b0});
   assign core_val  = use_imm ? DATA_W'(imm_val) : reg_val;
   assign core_kind = use_imm ? SK_ROR : kind_reg;
   assign core_amt  = use_imm ? imm_amt : dec_amt;
   assign bypass    = use_imm ? (imm_rot == '0) : amt_zero;

   op2_shift_core #(.DATA_W(DATA_W)) i_core (
      .val  (core_val),
      .kind (core_kind),
      .amt  (core_amt),
      .res  (core_res),
      .cout (core_c)
   );

   always_comb begin
      if (bypass) begin
         op2_out = core_val;
         shc_out = flag_c;
      end else if (!use_imm && keep_rot) begin
         op2_out = reg_val;
         shc_out = reg_val[DATA_W-1];
      end else if (!use_imm && force_zero) begin
         op2_out = '0;
         shc_out = 1'b0;
      end else begin
         op2_out = core_res;
         shc_out = core_c;
      end
   end
endmodule

// File: rtl/op2_barrel_checker.sv
module op2_barrel_checker #(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 8,
   parameter int ROT_W     = 4,
   parameter int FIELD_W   = 5,
   parameter int REG_AMT_W = 8
) (
   input logic                 use_imm,
   input logic [IMM_W-1:0]     imm_val,
   input logic [ROT_W-1:0]     imm_rot,
   input logic [DATA_W-1:0]    reg_val,
   input logic [1:0]           sh_kind,
   input logic                 amt_sel_reg,
   input logic [FIELD_W-1:0]   amt_imm,
   input logic [REG_AMT_W-1:0] amt_reg,
   input logic                 flag_c,
   input logic [DATA_W-1:0]    op2_out,
   input logic                 shc_out
);
   int cnt;
   assign cnt = amt_sel_reg ? int'(amt_reg) : int'(amt_imm);

   always_comb begin
      if (use_imm) begin
         a_r1_bits_kept: assert ($countones(op2_out) == $countones(imm_val));
         if (imm_rot == '0) begin
            a_r2_plain_imm: assert (op2_out == DATA_W'(imm_val) && shc_out == flag_c);
         end else begin
            a_r1_carry_msb: assert (shc_out == op2_out[DATA_W-1]);
         end
      end else begin
         if (cnt == 0) begin
            a_r4_zero_count: assert (op2_out == reg_val && shc_out == flag_c);
         end
         if (cnt > 0 && cnt < DATA_W && sh_kind == 2'b00) begin
            a_r3_lsl_carry: assert (shc_out == reg_val[DATA_W - cnt]);
         end
         if (cnt > DATA_W && !sh_kind[1]) begin
            a_r7_over_zero: assert (op2_out == '0 && !shc_out);
         end
         if (cnt >= DATA_W && sh_kind == 2'b10) begin
            a_r8_sign_fill: assert (op2_out == {DATA_W{reg_val[DATA_W-1]}}
                                    && shc_out == reg_val[DATA_W-1]);
         end
      end
   end
endmodule

bind op2_barrel_shifter op2_barrel_checker #(
   .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W),
   .FIELD_W(FIELD_W), .REG_AMT_W(REG_AMT_W)
) i_chk (.*);

// File: tb/test_op2_barrel_shifter.sv
`timescale 1ns/1ps
module test_op2_barrel_shifter;
   logic        clk = 1'b0;
   logic        use_imm, amt_sel_reg, flag_c, shc_out;
   logic [7:0]  imm_val, amt_reg;
   logic [3:0]  imm_rot;
   logic [31:0] reg_val, op2_out;
   logic [1:0]  sh_kind;
   logic [4:0]  amt_imm;
   int          n_chk = 0, n_fail = 0;
   bit          done = 0;

   always #2 clk = ~clk;

   op2_barrel_shifter i_op2_barrel_shifter (.*);

   function automatic logic [32:0] model(
      logic m, logic [7:0] iv, logic [3:0] ir, logic [31:0] v, logic [1:0] k,
      logic sr, logic [4:0] fa, logic [7:0] ra, logic ci);
      logic [31:0] r, x;
      logic        c;
      int          n, s;
      if (m) begin
         x = {24'd0, iv};
         s = 2 * int'(ir);
         if (s == 0) return {ci, x};
         for (int i = 0; i < 32; i++) r[i] = x[(i + s) % 32];
         return {r[31], r};
      end
      n = sr ? int'(ra) : int'(fa);
      if (n == 0) return {ci, v};
      r = '0; c = 1'b0;
      case (k)
         2'b00: if (n < 32) begin r = v << n; c = v[32 - n]; end
                else if (n == 32) c = v[0];
         2'b01: if (n < 32) begin r = v >> n; c = v[n - 1]; end
                else if (n == 32) c = v[31];
         2'b10: if (n >= 32) begin r = {32{v[31]}}; c = v[31]; end
                else begin r = 32'($signed(v) >>> n); c = v[n - 1]; end
         default: begin
            s = n % 32;
            if (s == 0) begin r = v; c = v[31]; end
            else begin
               for (int i = 0; i < 32; i++) r[i] = v[(i + s) % 32];
               c = v[s - 1];
            end
         end
      endcase
      return {c, r};
   endfunction

   function automatic string tag_of();
      int n;
      if (use_imm) return (imm_rot == 0) ? "R2" : "R1";
      n = amt_sel_reg ? int'(amt_reg) : int'(amt_imm);
      if (n == 0) return "R4";
      if (n < 32) return "R3";
      if (sh_kind == 2'b10) return "R8";
      if (sh_kind == 2'b11) return "R9";
      return (n == 32) ? "R6" : "R7";
   endfunction

   task automatic apply(logic m, logic [7:0] iv, logic [3:0] ir, logic [31:0] v,
                        logic [1:0] k, logic sr, logic [4:0] fa, logic [7:0] ra, logic ci);
      @(negedge clk);
      use_imm = m; imm_val = iv; imm_rot = ir; reg_val = v; sh_kind = k;
      amt_sel_reg = sr; amt_imm = fa; amt_reg = ra; flag_c = ci;
      @(posedge clk);
      #1;
   endtask

   task automatic check(string tag, logic [32:0] exp);
      n_chk++;
      if ({shc_out, op2_out} !== exp) begin
         n_fail++;
         $display("FAIL %s: got c=%b v=%h, expected c=%b v=%h",
                  tag, shc_out, op2_out, exp[32], exp[31:0]);
      end
   endtask

   task automatic run(logic m, logic [7:0] iv, logic [3:0] ir, logic [31:0] v,
                      logic [1:0] k, logic sr, logic [4:0] fa, logic [7:0] ra, logic ci);
      apply(m, iv, ir, v, k, sr, fa, ra, ci);
      check(tag_of(), model(m, iv, ir, v, k, sr, fa, ra, ci));
   endtask

   initial begin
      logic [32:0] ref_imm;
      void'($urandom(32'd2024));
      // all-zero inputs
      apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R4", 33'd0);
      // R2 / R1 immediates
      run(1, 8'hA5, 0, 32'h0, 0, 0, 0, 0, 1);
      check("R2", {1'b1, 32'h000000A5});
      run(1, 8'hFF, 4'd4, 32'h0, 0, 0, 0, 0, 0);
      check("R1", {1'b1, 32'hFF000000});
      run(1, 8'h01, 4'd1, 32'h0, 0, 0, 0, 0, 0);
      check("R1", {1'b0, 32'h40000000});
      run(1, 8'h81, 4'd15, 32'h0, 0, 0, 0, 0, 1);
      // R3 directed, each kind, counts 1 and 31
      for (int k = 0; k < 4; k++) begin
         run(0, 0, 0, 32'h8000_0001, 2'(k), 0, 5'd1, 0, 0);
         run(0, 0, 0, 32'hC3A5_5A3C, 2'(k), 0, 5'd31, 0, 1);
      end
      run(0, 0, 0, 32'h0000_0003, 2'b00, 0, 5'd3, 0, 0);
      check("R3", {1'b0, 32'h0000_0018});
      // R4 zero count from each source
      run(0, 0, 0, 32'h1234_5678, 2'b10, 0, 5'd0, 8'd77, 1);
      run(0, 0, 0, 32'h1234_5678, 2'b11, 1, 5'd9, 8'd0, 0);
      // R5 source selection
      apply(0, 0, 0, 32'h0000_0100, 2'b01, 0, 5'd4, 8'd200, 0);
      check("R5", {1'b0, 32'h0000_0010});
      apply(0, 0, 0, 32'h0000_0100, 2'b01, 1, 5'd4, 8'd2, 0);
      check("R5", {1'b0, 32'h0000_0040});
      // R6..R9 register count boundaries
      run(0, 0, 0, 32'h8000_0001, 2'b00, 1, 0, 8'd32, 0);
      check("R6", {1'b1, 32'h0});
      run(0, 0, 0, 32'h8000_0000, 2'b01, 1, 0, 8'd32, 0);
      check("R6", {1'b1, 32'h0});
      run(0, 0, 0, 32'hFFFF_FFFF, 2'b00, 1, 0, 8'd33, 1);
      run(0, 0, 0, 32'hFFFF_FFFF, 2'b01, 1, 0, 8'd255, 1);
      check("R7", 33'd0);
      run(0, 0, 0, 32'h8000_0000, 2'b10, 1, 0, 8'd32, 0);
      run(0, 0, 0, 32'h7FFF_FFFF, 2'b10, 1, 0, 8'd200, 1);
      check("R8", 33'd0);
      run(0, 0, 0, 32'h8765_4321, 2'b11, 1, 0, 8'd64, 0);
      check("R9", {1'b1, 32'h8765_4321});
      run(0, 0, 0, 32'h0000_00F0, 2'b11, 1, 0, 8'd36, 0);
      check("R9", {1'b0, 32'h0000_000F});
      // R10 immediate ignores register-side inputs
      ref_imm = model(1, 8'h3C, 4'd3, 0, 0, 0, 0, 0, 1);
      for (int t = 0; t < 8; t++) begin
         apply(1, 8'h3C, 4'd3, $urandom, 2'($urandom), 1'($urandom),
               5'($urandom), 8'($urandom), 1);
         check("R10", ref_imm);
      end
      // constrained random
      for (int t = 0; t < 4000; t++) begin
         logic [7:0] ra;
         case ($urandom_range(0, 5))
            0: ra = 8'd32;
            1: ra = 8'd33;
            2: ra = 8'(32 * $urandom_range(0, 7));
            3: ra = 8'($urandom_range(0, 1) ? 31 : 1);
            default: ra = 8'($urandom);
         endcase
         run(($urandom_range(0, 3) == 0), 8'($urandom), 4'($urandom), $urandom,
             2'($urandom), 1'($urandom), 5'($urandom), ra, 1'($urandom));
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule